// File: doc/BRIEF.md
# Immediate Operand Generator

This block turns a 32-bit fixed-length instruction word into the 64-bit immediate operand that the execute stage consumes. A select code arrives alongside the instruction word, and it picks one of six immediate formats. Four of the formats take the low 16-bit field. That field can be placed in the low half or shifted into bits 31:16, and it can be zero-extended or sign-extended. The other two formats produce word-aligned branch displacements, one from a 24-bit field and one from a 14-bit field. A valid flag tells the consumer whether the selected format carries an immediate at all.

The unit is purely combinational. The decoder ahead of it chooses the select code from the opcode. This block only extracts, places and extends the field, so the operand is ready in the same cycle as the instruction word.

Top module: `imm_gen`

## Requirements
- R1: With select code 0, the output is all zeros and the valid flag is low.
- R2: Select code 1 zero-extends instruction bits 15:0 into the output, so output bits 63:16 are zero.
- R3: Select code 2 places instruction bits 15:0 at output bits 31:16. Output bits 15:0 and 63:32 are zero.
- R4: Select code 3 sign-extends instruction bits 15:0, copying bit 15 into output bits 63:16.
- R5: Select code 4 shifts instruction bits 15:0 left by 16. It then sign-extends the 32-bit value from its bit 31, which is instruction bit 15. Output bits 15:0 are zero.
- R6: Select code 5 takes instruction bits 25:2 as a signed word count, multiplies it by 4 and sign-extends from instruction bit 25. Output bits 1:0 are zero.
- R7: Select code 6 takes instruction bits 15:2 as a signed word count, multiplies it by 4 and sign-extends from instruction bit 15. Output bits 1:0 are zero.
- R8: The valid flag is high exactly for select codes 1 through 6.
- R9: The unused select code 7 acts like code 0: the output is zero and the valid flag is low.
- R10: Instruction bits outside the field of the selected format have no effect on the output.
- R11: The output follows a change of either input within the same clock cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ins_word | input | 32 | Raw instruction word |
| imm_sel | input | 3 | Immediate format select (0 none, 1 unsigned, 2 unsigned-high, 3 signed, 4 signed-high, 5 long branch, 6 conditional branch, 7 unused) |
| imm_val | output | 64 | Extended immediate operand |
| imm_vld | output | 1 | High when the selected format supplies an immediate |

## Verification
The block holds no state, so a fault appears at the ports in the same cycle as the inputs that expose it. A wrong mux leg, a sign taken from the wrong bit or an off-by-one field boundary changes the output for any instruction word that exercises that bit. The bench therefore uses many random words for each select code, plus words with only the sign bit or only the field edges set. A fault in the valid flag or in the handling of the zero cases shows up as soon as code 0 or code 7 is applied.

// File: rtl/imm_gen_pkg.sv
package imm_gen_pkg;

    typedef enum logic [2:0] {
        SEL_NONE    = 3'd0,
        SEL_U16     = 3'd1,
        SEL_U16_HI  = 3'd2,
        SEL_S16     = 3'd3,
        SEL_S16_HI  = 3'd4,
        SEL_LONG_BR = 3'd5,
        SEL_COND_BR = 3'd6
    } imm_sel_e;

    localparam int unsigned HALF_W      = 16;
    localparam int unsigned WORD_SHIFT  = 2;
    localparam int unsigned LONG_BR_MSB = 25;
    localparam int unsigned COND_BR_MSB = 15;

endpackage

// File: rtl/imm_half_ext.sv
module imm_half_ext #(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned SHIFT  = 0,
    parameter bit          SIGNED = 1'b0
) (
    input  logic [imm_gen_pkg::HALF_W-1:0] field_i,
    output logic [XLEN-1:0]                ext_o
);
    localparam int unsigned TOP = SHIFT + imm_gen_pkg::HALF_W;

    logic fill_d;

    always_comb begin
        fill_d = SIGNED ? field_i[imm_gen_pkg::HALF_W-1] : 1'b0;
        for (int i = 0; i < int'(XLEN); i++) begin
            if (i < int'(SHIFT)) begin
                ext_o[i] = 1'b0;
            end else if (i < int'(TOP)) begin
                ext_o[i] = field_i[i-int'(SHIFT)];
            end else begin
                ext_o[i] = fill_d;
            end
        end
    end

endmodule

// File: rtl/imm_disp_ext.sv
module imm_disp_ext #(
    parameter int unsigned XLEN    = 64,
    parameter int unsigned FIELD_W = 24
) (
    input  logic [FIELD_W-1:0] words_i,
    output logic [XLEN-1:0]    disp_o
);
    localparam int unsigned LOW_W  = imm_gen_pkg::WORD_SHIFT;
    localparam int unsigned FILL_W = XLEN - FIELD_W - LOW_W;

    always_comb begin
        disp_o = {{FILL_W{words_i[FIELD_W-1]}}, words_i, {LOW_W{1'b0}}};
    end

endmodule

// File: rtl/imm_gen.sv
module imm_gen #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned ILEN = 32
) (
    input  logic [ILEN-1:0] ins_word,
    input  logic [2:0]      imm_sel,
    output logic [XLEN-1:0] imm_val,
    output logic            imm_vld
);
    import imm_gen_pkg::*;

    localparam int unsigned N_HALF  = 4;
    localparam int unsigned WS      = WORD_SHIFT;
    localparam int unsigned LONG_W  = LONG_BR_MSB - WS + 1;
    localparam int unsigned COND_W  = COND_BR_MSB - WS + 1;

    typedef struct packed {
        logic [XLEN-1:0] val;
        logic            vld;
    } imm_res_t;

    logic [XLEN-1:0] half_ext [N_HALF];
    logic [XLEN-1:0] long_disp;
    logic [XLEN-1:0] cond_disp;
    imm_res_t        res_d;

    // Index 0: unsigned, 1: unsigned-high, 2: signed, 3: signed-high
    for (genvar g = 0; g < int'(N_HALF); g++) begin : g_half
        imm_half_ext #(
            .XLEN   (XLEN),
            .SHIFT  ((g % 2 == 1) ? HALF_W : 0),
            .SIGNED (g >= 2)
        ) u_half (
            .field_i (ins_word[HALF_W-1:0]),
            .ext_o   (half_ext[g])
        );
    end

    imm_disp_ext #(
        .XLEN    (XLEN),
        .FIELD_W (LONG_W)
    ) u_long (
        .words_i (ins_word[LONG_BR_MSB:WS]),
        .disp_o  (long_disp)
    );

    imm_disp_ext #(
        .XLEN    (XLEN),
        .FIELD_W (COND_W)
    ) u_cond (
        .words_i (ins_word[COND_BR_MSB:WS]),
        .disp_o  (cond_disp)
    );

    always_comb begin
        res_d.val = '0;
        res_d.vld = 1'b1;
        case (imm_sel)
            SEL_U16:     res_d.val = half_ext[0];
            SEL_U16_HI:  res_d.val = half_ext[1];
            SEL_S16:     res_d.val = half_ext[2];
            SEL_S16_HI:  res_d.val = half_ext[3];
            SEL_LONG_BR: res_d.val = long_disp;
            SEL_COND_BR: res_d.val = cond_disp;
            default: begin
                res_d.val = '0;
                res_d.vld = 1'b0;
            end
        endcase
    end

    assign imm_val = res_d.val;
    assign imm_vld = res_d.vld;

endmodule

// File: rtl/imm_gen_chk.sv
module imm_gen_chk #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned ILEN = 32
) (
    input logic [ILEN-1:0] ins_word,
    input logic [2:0]      imm_sel,
    input logic [XLEN-1:0] imm_val,
    input logic            imm_vld
);
    always_comb begin
        assert_valid_range_R8: assert (imm_vld == (imm_sel >= 3'd1 && imm_sel <= 3'd6))
            else $error("valid flag disagrees with select code");
        assert_none_zero_R1: assert (imm_vld || imm_val == '0)
            else $error("no-immediate case drives nonzero value");
        assert_unused_code_R9: assert (imm_sel != 3'd7 || (!imm_vld && imm_val == '0))
            else $error("unused select code produced an immediate");
        assert_unsigned_top_R2: assert (imm_sel != 3'd1 || imm_val[XLEN-1:16] == '0)
            else $error("unsigned immediate has upper bits set");
        assert_unsigned_hi_R3: assert (imm_sel != 3'd2 ||
                (imm_val[15:0] == '0 && imm_val[XLEN-1:32] == '0 && imm_val[31:16] == ins_word[15:0]))
            else $error("unsigned-high placement wrong");
        assert_signed_fill_R4: assert (imm_sel != 3'd3 ||
                imm_val[XLEN-1:15] == '0 || imm_val[XLEN-1:15] == '1)
            else $error("signed immediate upper bits not a uniform sign copy");
        assert_signed_hi_low_R5: assert (imm_sel != 3'd4 ||
                (imm_val[15:0] == '0 && (imm_val[XLEN-1:31] == '0 || imm_val[XLEN-1:31] == '1)))
            else $error("signed-high immediate malformed");
        assert_long_align_R6: assert (imm_sel != 3'd5 || imm_val[1:0] == 2'b00)
            else $error("long branch displacement not word aligned");
        assert_cond_align_R7: assert (imm_sel != 3'd6 || imm_val[1:0] == 2'b00)
            else $error("conditional branch displacement not word aligned");
    end

endmodule

bind imm_gen imm_gen_chk #(
    .XLEN (XLEN),
    .ILEN (ILEN)
) u_chk (
    .ins_word (ins_word),
    .imm_sel  (imm_sel),
    .imm_val  (imm_val),
    .imm_vld  (imm_vld)
);

// File: tb/sim_imm_gen.sv
`timescale 1ns/1ps
module sim_imm_gen;

    localparam int unsigned XLEN = 64;
    localparam int unsigned ILEN = 32;

    logic            clk = 1'b0;
    logic [ILEN-1:0] ins_word = '0;
    logic [2:0]      imm_sel = '0;
    logic [XLEN-1:0] imm_val;
    logic            imm_vld;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    imm_gen #(.XLEN(XLEN), .ILEN(ILEN)) u0 (
        .ins_word (ins_word),
        .imm_sel  (imm_sel),
        .imm_val  (imm_val),
        .imm_vld  (imm_vld)
    );

    function automatic longint sext(longint v, int w);
        longint lim = longint'(1) <<< w;
        if (v >= (lim >>> 1)) return v - lim;
        return v;
    endfunction

    function automatic logic [63:0] ref_val(logic [2:0] s, logic [31:0] w);
        longint lo = longint'({32'b0, w}) & 64'hFFFF;
        longint f;
        case (s)
            3'd1: return lo;
            3'd2: return lo * 65536;
            3'd3: return sext(lo, 16);
            3'd4: return sext(lo, 16) * 65536;
            3'd5: begin
                f = (longint'({32'b0, w}) / 4) & 64'hFFFFFF;
                return sext(f, 24) * 4;
            end
            3'd6: begin
                f = (lo / 4) & 64'h3FFF;
                return sext(f, 14) * 4;
            end
            default: return 64'd0;
        endcase
    endfunction

    function automatic logic ref_vld(logic [2:0] s);
        return (s >= 3'd1) && (s <= 3'd6);
    endfunction

    task automatic apply(input logic [2:0] s, input logic [31:0] w);
        @(posedge clk);
        imm_sel  = s;
        ins_word = w;
        @(negedge clk);
    endtask

    task automatic cmp(input string tag, input logic [63:0] exp_v, input logic exp_f);
        n_checks++;
        if (imm_val !== exp_v || imm_vld !== exp_f) begin
            n_fail++;
            $display("FAIL %s sel=%0d ins=%h: got val=%h vld=%b, expected val=%h vld=%b",
                     tag, imm_sel, ins_word, imm_val, imm_vld, exp_v, exp_f);
        end
    endtask

    task automatic run(input string tag, input logic [2:0] s, input logic [31:0] w);
        apply(s, w);
        cmp(tag, ref_val(s, w), ref_vld(s));
    endtask

    function automatic string tag_of(logic [2:0] s);
        case (s)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            3'd7: return "R9";
            default: return "R1";
        endcase
    endfunction

    initial begin
        #(8.0 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] first_v;
        void'($urandom(32'd20240611));

        // Initial state with code 0 (R1)
        @(negedge clk);
        cmp("R1", 64'd0, 1'b0);

        // Directed corner cases
        run("R1", 3'd0, 32'hFFFF_FFFF);
        cmp("R1", 64'd0, 1'b0);
        run("R9", 3'd7, 32'hFFFF_FFFF);
        cmp("R9", 64'd0, 1'b0);
        run("R2", 3'd1, 32'hFFFF_8000);
        cmp("R2", 64'h0000_0000_0000_8000, 1'b1);
        run("R3", 3'd2, 32'h0000_FFFF);
        cmp("R3", 64'h0000_0000_FFFF_0000, 1'b1);
        run("R4", 3'd3, 32'h0000_8000);
        cmp("R4", 64'hFFFF_FFFF_FFFF_8000, 1'b1);
        run("R4", 3'd3, 32'hFFFF_7FFF);
        cmp("R4", 64'h0000_0000_0000_7FFF, 1'b1);
        run("R5", 3'd4, 32'h0000_8000);
        cmp("R5", 64'hFFFF_FFFF_8000_0000, 1'b1);
        run("R5", 3'd4, 32'h0000_7FFF);
        cmp("R5", 64'h0000_0000_7FFF_0000, 1'b1);
        run("R6", 3'd5, 32'h03FF_FFFC);
        cmp("R6", 64'hFFFF_FFFF_FFFF_FFFC, 1'b1);
        run("R6", 3'd5, 32'hFDFF_FFFF);
        cmp("R6", 64'h0000_0000_01FF_FFFC, 1'b1);
        run("R6", 3'd5, 32'h0200_0000);
        cmp("R6", 64'hFFFF_FFFF_FE00_0000, 1'b1);
        run("R7", 3'd6, 32'hFFFF_8003);
        cmp("R7", 64'hFFFF_FFFF_FFFF_8000, 1'b1);
        run("R7", 3'd6, 32'h0000_7FFF);
        cmp("R7", 64'h0000_0000_0000_7FFC, 1'b1);

        // R10: upper instruction bits must not disturb the data immediates
        for (int s = 1; s <= 4; s++) begin
            apply(3'(s), 32'h0000_A5C3);
            first_v = imm_val;
            apply(3'(s), 32'hFFFF_A5C3);
            cmp("R10", first_v, 1'b1);
        end
        apply(3'd6, 32'h0000_1234);
        first_v = imm_val;
        apply(3'd6, 32'hFFFF_1237);
        cmp("R10", first_v, 1'b1);

        // R11 and R8: output tracks the select change within the same cycle
        for (int s = 0; s < 8; s++) begin
            run("R11", 3'(s), 32'h8765_4321);
        end

        // Random sweep across every select code
        for (int k = 0; k < 4000; k++) begin
            logic [2:0]  s = 3'($urandom_range(0, 7));
            logic [31:0] w = $urandom();
            run(tag_of(s), s, w);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule